// File: doc/BRIEF.md
# I2C Slave Byte Engine with Double Buffering

This block is the byte-level data path of an I2C target. A CPU sees a four-entry register bus: the own-address register, a transmit holding byte, a receive holding byte and a status word. A single internal shift register, which software cannot reach, sits between the holding bytes and the SDA line. It clocks bits in or out on SCL edges, so the CPU can refill or drain a holding byte while the next byte moves on the wire.

SCL and SDA pass through a short synchronizer. START and STOP are recognised from SDA moving while SCL is high. After every START, the first frame is taken as an address frame. Its upper seven bits are compared with the programmed address. On a match the block pulses `addr_match`, reports the direction bit and takes part in the transfer until the next START or STOP. Bit 0 of the frame selects the direction: 0 means the controller writes to the block, and 1 means the controller reads from it. The block acknowledges the address and every byte written to it. Bytes are transferred MSB first.

Register map, selected by `bus_addr`:
- 0: own address. Bits 7..1 are the address. Bit 0 is reserved, and software should write 0 to it.
- 1: transmit holding byte.
- 2: receive holding byte.
- 3: status. Bit 0 is tx_empty, bit 1 is rx_full and bit 2 is overrun.

Top module: `i2c_byte_engine`

## Requirements
- R1: Register 0 stores all 8 written bits and reads them back unchanged, bit 0 included. Only bits 7..1 take part in address comparison.
- R2: When bits 7..1 of the first frame after a START equal register bits 7..1, `addr_match` is high for exactly one clock cycle, and `match_rw` shows bit 0 of that frame.
- R3: A first frame that does not match the address gives no match pulse and no acknowledge. Data bytes that follow it are neither acknowledged nor stored.
- R4: Only the first frame after a START is compared with the address. A later data byte equal to the address does not pulse `addr_match`. A repeated START re-arms the comparison.
- R5: In a write transfer, the eight bits are sampled MSB first on SCL rising edges. The completed byte moves to the receive holding byte and sets rx_full (status bit 1). A bus read of register 2 clears rx_full.
- R6: If a byte completes while rx_full is set, overrun (status bit 2) is set and the earlier byte stays in the receive holding byte. Writing status with bit 2 set clears overrun.
- R7: Bus writes to register 2 have no effect on the receive holding byte or on rx_full.
- R8: Writing register 1 clears tx_empty (status bit 0). In a read transfer, a byte moves from the holding byte into the free shift register during the acknowledge clock, and tx_empty is set again. The byte is then sent MSB first, and the block changes SDA only while SCL is low.
- R9: A byte written while the previous byte is still shifting out is sent in the very next frame, with no extra clocks.
- R10: During the ninth clock, the block pulls SDA low after a matched address frame and after each data byte of a write transfer.
- R11: After a STOP, clocked bits are ignored until the next START: no acknowledge is given and nothing is stored.
- R12: After reset, status reads 0x01, register 0 reads 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe. Reading register 2 with it clears rx_full |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_match | output | 1 | One-cycle pulse on an own-address match |
| match_rw | output | 1 | Direction bit of the last matched address frame |

## Verification
The bench sends a data byte equal to the address frame. A design that compares every frame would give an extra match pulse, which the match scoreboard reports. It also sends a byte while the receive side is still full. A design that overwrote the old byte would return the new byte instead of the preserved one. It programs bit 0 of the address register to 1 and then addresses the block with bit 0 equal to 0. A comparison over all eight bits would lose the acknowledge. Finally, it writes the second transmit byte while the first is still on the wire. A late reload, or a misplaced start of the shift, shows up as a wrong bit in the second byte read back, and any SDA change while SCL is high is counted by a line monitor.

// File: rtl/i2c_eng_pkg.sv
// Package: shared constants and register select codes for the I2C byte engine.
// Assumes an 8-bit byte and a 7-bit address as fixed by the bus protocol.
package i2c_eng_pkg;
    localparam int BYTE_W = 8;
    localparam int SA_W   = BYTE_W - 1;
    localparam int RA_W   = 2;

    typedef enum logic [RA_W-1:0] {
        REG_OWN_ADDR = 2'd0,
        REG_TX_HOLD  = 2'd1,
        REG_RX_HOLD  = 2'd2,
        REG_STATUS   = 2'd3
    } reg_sel_e;

    localparam int ST_TX_EMPTY = 0;
    localparam int ST_RX_FULL  = 1;
    localparam int ST_OVERRUN  = 2;
endpackage

// File: rtl/i2c_line_sense.sv
// Module: synchronizes SCL/SDA and detects SCL edges, START and STOP.
// Assumes both lines idle high; reset fills the chains with ones.
module i2c_line_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
    logic scl_q, sda_q;

    // Synchronizer chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
            scl_q     <= scl_s;
            sda_q     <= sda_s;
        end
    end

    // Edge and bus-condition decode from current and previous samples.
    always_comb begin
        scl_s     = scl_chain[SYNC_STAGES-1];
        sda_s     = sda_chain[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_regfile.sv
// Module: CPU-visible registers: own address, transmit/receive holding bytes, status.
// Assumes single-cycle bus strobes; reading the receive byte clears rx_full.
module i2c_regfile
    import i2c_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [RA_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              tx_pop,
    output logic [SA_W-1:0]   own_addr,
    output logic              tx_full,
    output logic [BYTE_W-1:0] tx_byte
);
    reg_sel_e          sel;
    logic [BYTE_W-1:0] own_q, tx_q, rx_q;
    logic              tx_full_q, rx_full_q, ovr_q;
    logic              rd_clr, ovr_clr;

    // Bus decode.
    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        rd_clr  = bus_rd && (sel == REG_RX_HOLD);
        ovr_clr = bus_wr && (sel == REG_STATUS) && bus_wdata[ST_OVERRUN];
    end

    // Own-address register, all eight bits stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                           own_q <= '0;
        else if (bus_wr && sel == REG_OWN_ADDR) own_q <= bus_wdata;
    end

    // Transmit holding byte: CPU write fills, shifter load empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q      <= '0;
            tx_full_q <= 1'b0;
        end else if (bus_wr && sel == REG_TX_HOLD) begin
            tx_q      <= bus_wdata;
            tx_full_q <= 1'b1;
        end else if (tx_pop) begin
            tx_full_q <= 1'b0;
        end
    end

    // Receive holding byte with overrun that preserves the older byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q      <= '0;
            rx_full_q <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (rx_push && rx_full_q && !rd_clr) begin
                ovr_q <= 1'b1;
            end else if (rx_push) begin
                rx_q      <= rx_byte;
                rx_full_q <= 1'b1;
            end else if (rd_clr) begin
                rx_full_q <= 1'b0;
            end
            if (ovr_clr && !(rx_push && rx_full_q && !rd_clr)) ovr_q <= 1'b0;
        end
    end

    // Read mux and outputs toward the shifter.
    always_comb begin
        unique case (sel)
            REG_OWN_ADDR: bus_rdata = own_q;
            REG_TX_HOLD:  bus_rdata = tx_q;
            REG_RX_HOLD:  bus_rdata = rx_q;
            default: begin
                bus_rdata = '0;
                bus_rdata[ST_TX_EMPTY] = ~tx_full_q;
                bus_rdata[ST_RX_FULL]  = rx_full_q;
                bus_rdata[ST_OVERRUN]  = ovr_q;
            end
        endcase
        own_addr = own_q[BYTE_W-1:1];
        tx_full  = tx_full_q;
        tx_byte  = tx_q;
    end

    assert_overrun_keeps_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full_q && !rd_clr) |=> ($stable(rx_q) && ovr_q));
    assert_read_clears_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !rx_push) |=> !rx_full_q);
    assert_rx_not_writable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_RX_HOLD && !rx_push) |=> $stable(rx_q));
    assert_pop_needs_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_full_q);
endmodule

// File: rtl/i2c_shifter.sv
// Module: bit counter, shared shift register, address compare and SDA drive.
// Assumes synchronized SCL/SDA with single-cycle edge strobes; frames are
// 8 data bits plus one acknowledge clock, MSB first.
module i2c_shifter
    import i2c_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [SA_W-1:0]   own_addr,
    input  logic              tx_full,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              addr_match,
    output logic              match_rw,
    output logic              sda_pull
);
    localparam int CNT_W    = $clog2(BYTE_W + 1);
    localparam int ACK_SLOT = BYTE_W;
    localparam int LAST_BIT = BYTE_W - 1;

    logic              active, got_rise, addr_phase, sel, tx_dir, ack_pend, sh_busy;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg, frame_byte, rx_byte_q;
    logic              match_q, rw_q, push_q;
    logic              in_ack, bit_end, byte_done, shift_in, shift_out, load, hit;

    // Frame event decode.
    always_comb begin
        in_ack     = (bit_cnt == CNT_W'(ACK_SLOT));
        bit_end    = active && scl_fall && got_rise;
        frame_byte = {shreg[BYTE_W-2:0], sda_s};
        byte_done  = active && scl_rise && (bit_cnt == CNT_W'(LAST_BIT));
        shift_in   = active && scl_rise && !in_ack && !(sel && tx_dir);
        shift_out  = bit_end && sel && tx_dir && !in_ack;
        load       = active && sel && tx_dir && !sh_busy && tx_full && in_ack;
        hit        = (frame_byte[BYTE_W-1:1] == own_addr);
    end

    // Bit counter: advances on each SCL fall that follows a rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0; got_rise <= 1'b0; bit_cnt <= '0;
        end else if (start_det) begin
            active <= 1'b1; got_rise <= 1'b0; bit_cnt <= '0;
        end else if (stop_det) begin
            active <= 1'b0; got_rise <= 1'b0; bit_cnt <= '0;
        end else if (active && scl_rise) begin
            got_rise <= 1'b1;
        end else if (bit_end) begin
            got_rise <= 1'b0;
            bit_cnt  <= in_ack ? '0 : bit_cnt + CNT_W'(1);
        end
    end

    // Address phase, selection, acknowledge and receive hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_phase <= 1'b0; sel <= 1'b0; tx_dir <= 1'b0; ack_pend <= 1'b0;
            match_q <= 1'b0; rw_q <= 1'b0; push_q <= 1'b0; rx_byte_q <= '0;
        end else begin
            match_q <= 1'b0;
            push_q  <= 1'b0;
            if (start_det || stop_det) begin
                addr_phase <= start_det;
                sel <= 1'b0; tx_dir <= 1'b0; ack_pend <= 1'b0;
            end else if (byte_done && addr_phase) begin
                addr_phase <= 1'b0;
                if (hit) begin
                    sel      <= 1'b1;
                    tx_dir   <= frame_byte[0];
                    ack_pend <= 1'b1;
                    match_q  <= 1'b1;
                    rw_q     <= frame_byte[0];
                end
            end else if (byte_done && sel && !tx_dir) begin
                push_q    <= 1'b1;
                rx_byte_q <= frame_byte;
                ack_pend  <= 1'b1;
            end else if (bit_end && in_ack) begin
                ack_pend <= 1'b0;
            end
        end
    end

    // Shared shift register: load from holding byte, shift in or out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0; sh_busy <= 1'b0;
        end else if (start_det || stop_det) begin
            sh_busy <= 1'b0;
        end else if (load) begin
            shreg   <= tx_byte;
            sh_busy <= 1'b1;
        end else if (shift_in) begin
            shreg <= frame_byte;
        end else if (shift_out) begin
            shreg <= {shreg[BYTE_W-2:0], 1'b0};
            if (bit_cnt == CNT_W'(LAST_BIT)) sh_busy <= 1'b0;
        end
    end

    // SDA drive: acknowledge slot or transmit data bit.
    always_comb begin
        sda_pull   = active && ((in_ack && ack_pend) ||
                                (sel && tx_dir && sh_busy && !in_ack && !shreg[BYTE_W-1]));
        tx_pop     = load;
        rx_push    = push_q;
        rx_byte    = rx_byte_q;
        addr_match = match_q;
        match_rw   = rw_q;
    end

    assert_match_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |=> !addr_match);
    assert_sda_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && !$past(start_det || stop_det)) |-> !scl_s);
    assert_push_only_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (sel && !tx_dir));
endmodule

// File: rtl/i2c_byte_engine.sv
// Module: top of the double-buffered I2C target byte engine.
// Assumes an open-drain SDA: sda_pull=1 drives the line low outside this block.
module i2c_byte_engine
    import i2c_eng_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_pull,
    output logic        addr_match,
    output logic        match_rw
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic rx_push, tx_pop, tx_full;
    logic [BYTE_W-1:0] rx_byte, tx_byte;
    logic [SA_W-1:0]   own_addr;

    i2c_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_pop(tx_pop),
        .own_addr(own_addr), .tx_full(tx_full), .tx_byte(tx_byte)
    );

    i2c_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .own_addr(own_addr), .tx_full(tx_full), .tx_byte(tx_byte),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
        .addr_match(addr_match), .match_rw(match_rw), .sda_pull(sda_pull)
    );
endmodule

// File: tb/tb_i2c_byte_engine.sv
module tb_i2c_byte_engine;
    localparam int H = 10;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_line, sda_pull, addr_match, match_rw;

    int checks = 0, failures = 0, line_viol = 0;
    logic [7:0] rx_exp[$];
    logic       match_exp[$];
    logic       prev_match = 1'b0, prev_pull = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    i2c_byte_engine dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull),
        .addr_match(addr_match), .match_rw(match_rw)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    // Scoreboard pop: CPU drains the receive byte, compared with the driver's item.
    task automatic cpu_pop_rx(input string tag);
        logic [7:0] d;
        cpu_rd(2'd2, d);
        if (rx_exp.size() == 0) chk({tag, " no expected item"}, d, 8'hxx);
        else chk(tag, d, rx_exp.pop_front());
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(Q);
        sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(H);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wclk(H); scl_m = 1'b1; wclk(Q); sda_m = 1'b1; wclk(Q);
    endtask

    task automatic send_bit(input logic b);
        wclk(H); sda_m = b; wclk(H); scl_m = 1'b1; wclk(Q); scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(H);
        ack = (sda_line == 1'b0);
        wclk(H); scl_m = 1'b0;
    endtask

    // Driver: sends an address frame and queues the expected match direction.
    task automatic send_addr(input logic [7:0] b, input logic expect_hit, output logic ack);
        if (expect_hit) match_exp.push_back(b[0]);
        write_byte(b, ack);
    endtask

    // Driver: sends a data byte and queues it when it should be stored.
    task automatic send_data(input logic [7:0] b, input logic expect_store, output logic ack);
        if (expect_store) rx_exp.push_back(b);
        write_byte(b, ack);
    endtask

    task automatic read_byte(output logic [7:0] b, input logic give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(Q); scl_m = 1'b1; wclk(H); b[i] = sda_line; wclk(H); scl_m = 1'b0;
        end
        send_bit(~give_ack);
    endtask

    // Monitor: pops the match scoreboard on each pulse and checks pulse width.
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_match && prev_match) chk("R2 match pulse wider than one cycle", 8'd1, 8'd0);
            else if (addr_match) begin
                if (match_exp.size() == 0) chk("R4 unexpected address match", 8'd1, 8'd0);
                else chk("R2 match_rw", {7'd0, match_rw}, {7'd0, match_exp.pop_front()});
            end
            if (sda_pull !== prev_pull && scl_m) line_viol++;
        end
        prev_match = addr_match;
        prev_pull  = sda_pull;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic ack;
        wclk(5); rst_n = 1'b1; wclk(3);

        // R12 reset state
        cpu_rd(2'd3, d); chk("R12 status after reset", d, 8'h01);
        cpu_rd(2'd0, d); chk("R12 own address after reset", d, 8'h00);
        chk("R12 sda released", {7'd0, sda_pull}, 8'd0);

        // R1 own address readback, reserved bit kept
        cpu_wr(2'd0, 8'hA5);
        cpu_rd(2'd0, d); chk("R1 own address readback", d, 8'hA5);

        // R2/R10 write transfer; frame bit 0 differs from register bit 0
        i2c_start();
        send_addr(8'hA4, 1'b1, ack); chk("R10 ack after matched address", {7'd0, ack}, 8'd1);
        send_data(8'h3C, 1'b1, ack); chk("R10 ack after data byte", {7'd0, ack}, 8'd1);
        cpu_rd(2'd3, d); chk("R5 rx_full set", d, 8'h03);
        cpu_pop_rx("R5 received byte");
        cpu_rd(2'd3, d); chk("R5 read clears rx_full", d, 8'h01);

        // R4 data byte equal to the address frame is plain data
        send_data(8'hA4, 1'b1, ack);
        cpu_pop_rx("R4 address-valued data byte");

        // R6 overrun keeps the older byte
        send_data(8'h11, 1'b1, ack);
        send_data(8'h22, 1'b0, ack); chk("R10 ack on overrun byte", {7'd0, ack}, 8'd1);
        cpu_rd(2'd3, d); chk("R6 overrun flagged", d, 8'h07);
        cpu_pop_rx("R6 older byte kept");
        cpu_rd(2'd3, d); chk("R6 overrun remains after read", d, 8'h05);
        cpu_wr(2'd3, 8'h04);
        cpu_rd(2'd3, d); chk("R6 overrun cleared", d, 8'h01);

        // R7 CPU write to receive byte ignored
        cpu_wr(2'd2, 8'h99);
        cpu_rd(2'd2, d); chk("R7 receive byte unchanged", d, 8'h11);
        cpu_rd(2'd3, d); chk("R7 rx_full unchanged", d, 8'h01);
        i2c_stop();

        // R11 clocks after STOP are ignored
        scl_m = 1'b0; wclk(H);
        write_byte(8'h55, ack); chk("R11 no ack after stop", {7'd0, ack}, 8'd0);
        cpu_rd(2'd3, d); chk("R11 nothing stored after stop", d, 8'h01);

        // R3 non-matching address
        i2c_start();
        send_addr(8'h80, 1'b0, ack); chk("R3 no ack on foreign address", {7'd0, ack}, 8'd0);
        send_data(8'h77, 1'b0, ack); chk("R3 no ack on foreign data", {7'd0, ack}, 8'd0);
        cpu_rd(2'd3, d); chk("R3 nothing stored", d, 8'h01);

        // R8/R9 repeated START into a read transfer
        cpu_wr(2'd1, 8'hC3);
        cpu_rd(2'd3, d); chk("R8 tx_empty cleared by write", d, 8'h00);
        i2c_start();
        send_addr(8'hA5, 1'b1, ack); chk("R10 ack after read address", {7'd0, ack}, 8'd1);
        cpu_rd(2'd3, d); chk("R8 byte moved to shift register", d, 8'h01);
        cpu_wr(2'd1, 8'h5A);
        read_byte(d, 1'b1); chk("R8 first transmitted byte", d, 8'hC3);
        cpu_rd(2'd3, d); chk("R9 second byte loaded", d, 8'h01);
        read_byte(d, 1'b0); chk("R9 back-to-back byte", d, 8'h5A);
        i2c_stop();

        chk("R4 all expected matches seen", 8'(match_exp.size()), 8'd0);
        chk("R8 SDA changed only while SCL low", 8'(line_viol), 8'd0);
        chk("R5 receive scoreboard drained", 8'(rx_exp.size()), 8'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule